// File: doc/BRIEF.md
# Prioritized Interrupt Pending Controller

This block gathers sixteen interrupt sources and selects one of them for the processor. Eight sources are external request pins and eight are internal interrupt levels. Both kinds are placed in a single priority order that alternates between them: pin 0 first, then level 0, then pin 1, then level 1, and so on. The last two entries are pin 7 and level 7. A source's position in this order is its priority index, running from 0 to 15. Index 0 has the highest priority.

Software reaches the block over a small register bus. The bus has a word-wide read-only pending register, a read/write mask register and a read-only vector register. The vector register carries a one-byte code for the winning source. The code is four times the winner's index, so software can add it directly to the base of a table of 4-byte handler entries. One request line goes to the core. It stays high while any pending source is also unmasked.

Both registers number their bits from the MSB: priority index i sits at word bit 31−i. As an example, writing 0x4000_0000 to the mask enables only index 1, which is internal level 0.

Top module: `irq_pend_ctrl`

## Requirements
- R1: While reset is active and after it is released, the pending and mask registers read zero, `irq_req` is low and `irq_vector` is 0x40.
- R2: Pin k has priority index 2k and level k has index 2k+1. The pending register (bus address 0) holds index i at bit 31−i and reads 0 in bits 15:0. Each pending bit follows its level-sensitive input one clock after the input is sampled.
- R3: A bus write to address 0 has no effect on the pending register.
- R4: The mask register is at bus address 1, with index i at bit 31−i. Writes load bits 31:16, bits 15:0 always read 0, and the mask holds its value when it is not written.
- R5: `irq_req` is high exactly when at least one source is both pending and unmasked. A masked source never raises it.
- R6: The winner is the pending, unmasked source with the lowest priority index.
- R7: `irq_vector` equals four times the winner's index. A read of address 2 returns this code in bits 31:24, with zeros below it.
- R8: When no source is both pending and unmasked, the vector code is 0x40.
- R9: A read of address 3 returns zero, and `bus_rdata` is zero whenever `bus_sel` is low or a write is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_req | input | 8 | External pin requests, level-sensitive |
| level_req | input | 8 | Internal level requests, level-sensitive |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 pending, 1 mask, 2 vector, 3 reserved |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vector | output | 8 | Code of the winning source |

## Verification
The bench builds the block with its default sizes: eight pins and eight levels, giving 16 sources. With 16 sources, every one of the 65,536 pending patterns can be swept under a fully open mask. At each step the bench checks the request line, the vector code and the pending word read back over the bus. Further sweeps run under masks that allow only pins, only levels, only index 1, only index 0 or only index 15. These sweeps exercise the interleaved ordering and the ranking of masked and unmasked sources against each other.

// File: rtl/irq_pc_pkg.sv
package irq_pc_pkg;

  typedef enum logic [1:0] {
    RA_PEND = 2'd0,
    RA_MASK = 2'd1,
    RA_VEC  = 2'd2,
    RA_RSVD = 2'd3
  } reg_addr_e;

  localparam int unsigned CODE_STRIDE = 4;

endpackage

// File: rtl/irq_src_capture.sv
module irq_src_capture #(
  parameter int unsigned NUM_PINS = 8,
  localparam int unsigned NUM_SRC = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_req,
  input  logic [NUM_PINS-1:0] level_req,
  output logic [NUM_SRC-1:0]  pend_q
);

  logic [NUM_SRC-1:0] order_vec;

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_weave
    assign order_vec[2*k]   = pin_req[k];
    assign order_vec[2*k+1] = level_req[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= order_vec;
  end

  p_pend_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pend_q[0] == $past(pin_req[0]) && pend_q[1] == $past(level_req[0])));

  p_pend_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pend_q[NUM_SRC-1] == $past(level_req[NUM_PINS-1])
                      && pend_q[NUM_SRC-2] == $past(pin_req[NUM_PINS-1])));

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned BUS_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [BUS_W-1:0]   wdata,
  output logic [NUM_SRC-1:0] mask_q
);

  logic [NUM_SRC-1:0] mask_d;
  logic               unused_low;

  assign unused_low = ^wdata[BUS_W-NUM_SRC-1:0];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_unpack
    assign mask_d[i] = wdata[BUS_W-1-i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= mask_d;
  end

  p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en)) |-> $stable(mask_q));

  p_mask_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mask_q[0] == $past(wdata[BUS_W-1])));

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned VEC_W   = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC),
  localparam logic [VEC_W-1:0] NONE_CODE = VEC_W'(NUM_SRC * irq_pc_pkg::CODE_STRIDE)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] act,
  output logic               any,
  output logic [VEC_W-1:0]   code
);

  logic [NUM_SRC:0]   seen;
  logic [NUM_SRC-1:0] grant;
  logic [IDX_W-1:0]   win_idx;

  function automatic logic [VEC_W-1:0] idx_to_code(input logic [IDX_W-1:0] idx);
    return VEC_W'(idx) * VEC_W'(irq_pc_pkg::CODE_STRIDE);
  endfunction

  function automatic logic [NUM_SRC-1:0] below(input logic [VEC_W-1:0] c);
    logic [NUM_SRC-1:0] r;
    for (int i = 0; i < NUM_SRC; i++)
      r[i] = (VEC_W'(i * irq_pc_pkg::CODE_STRIDE) < c);
    return r;
  endfunction

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
    assign grant[i]  = act[i] & ~seen[i];
    assign seen[i+1] = seen[i] | act[i];
  end

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (grant[i]) win_idx = win_idx | IDX_W'(i);
  end

  assign any  = seen[NUM_SRC];
  assign code = any ? idx_to_code(win_idx) : NONE_CODE;

  p_grant_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_winner_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> act[code[VEC_W-1:2]]);

  p_none_lower_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((act & below(code)) == '0));

  p_code_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    code[1:0] == 2'b00);

  p_idle_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !any |-> (code == NONE_CODE));

endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned BUS_W    = 32,
  parameter int unsigned VEC_W    = 8,
  localparam int unsigned NUM_SRC = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_req,
  input  logic [NUM_PINS-1:0] level_req,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [1:0]          bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  output logic                irq_req,
  output logic [VEC_W-1:0]    irq_vector
);
  import irq_pc_pkg::*;

  localparam logic [VEC_W-1:0] NONE_CODE = VEC_W'(NUM_SRC * CODE_STRIDE);

  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] active;
  logic               mask_wr;
  reg_addr_e          ra;

  function automatic logic [BUS_W-1:0] order_to_word(input logic [NUM_SRC-1:0] v);
    logic [BUS_W-1:0] w;
    w = '0;
    for (int i = 0; i < NUM_SRC; i++) w[BUS_W-1-i] = v[i];
    return w;
  endfunction

  assign ra      = reg_addr_e'(bus_addr);
  assign mask_wr = bus_sel & bus_wr & (ra == RA_MASK);

  irq_src_capture #(.NUM_PINS(NUM_PINS)) cap_i (
    .clk, .rst_n, .pin_req, .level_req, .pend_q
  );

  irq_mask_bank #(.NUM_SRC(NUM_SRC), .BUS_W(BUS_W)) msk_i (
    .clk, .rst_n, .wr_en(mask_wr), .wdata(bus_wdata), .mask_q
  );

  assign active = pend_q & mask_q;

  irq_prio_pick #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) pick_i (
    .clk, .rst_n, .act(active), .any(irq_req), .code(irq_vector)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (ra)
        RA_PEND: bus_rdata = order_to_word(pend_q);
        RA_MASK: bus_rdata = order_to_word(mask_q);
        RA_VEC:  bus_rdata = {irq_vector, {(BUS_W-VEC_W){1'b0}}};
        RA_RSVD: bus_rdata = '0;
      endcase
    end
  end

  p_req_vs_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (irq_vector != NONE_CODE));

  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_req);

  p_rd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (bus_rdata == '0));

endmodule

// File: tb/irq_pend_ctrl_tb_top.sv
module irq_pend_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_req = '0;
  logic [7:0]  level_req = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_req;
  logic [7:0]  irq_vector;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pend_ctrl dut_i (
    .clk, .rst_n, .pin_req, .level_req, .bus_sel, .bus_wr, .bus_addr,
    .bus_wdata, .bus_rdata, .irq_req, .irq_vector
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // index-space source vector: bit 2k = pin k, bit 2k+1 = level k
  task automatic drive(input logic [15:0] s);
    for (int k = 0; k < 8; k++) begin
      pin_req[k]   = s[2*k];
      level_req[k] = s[2*k+1];
    end
  endtask

  function automatic logic [7:0] exp_code(input logic [15:0] s, input logic [15:0] m);
    for (int i = 0; i < 16; i++)
      if (s[i] && m[i]) return 8'(i << 2);
    return 8'h40;
  endfunction

  function automatic logic [31:0] to_word(input logic [15:0] s);
    logic [31:0] w = '0;
    for (int i = 0; i < 16; i++) w[31-i] = s[i];
    return w;
  endfunction

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
    #1;
  endtask

  task automatic sweep(input logic [15:0] m, input int count, input int mul, input string tag);
    logic [15:0] prev = '0;
    logic [31:0] rd;
    for (int p = 0; p <= count; p++) begin
      @(negedge clk);
      if (p > 0) begin
        chk(irq_req == ((prev & m) != 0), {"R5 ", tag}, 32'(irq_req), 32'((prev & m) != 0));
        chk(irq_vector == exp_code(prev, m), {"R6/R7/R8 ", tag}, 32'(irq_vector), 32'(exp_code(prev, m)));
        bus_read(2'd0, rd);
        chk(rd == to_word(prev), {"R2 ", tag}, rd, to_word(prev));
      end
      if (p < count) begin
        prev = 16'(p * mul);
        drive(prev);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    // R1: inputs high during reset must not show
    drive(16'hFFFF);
    repeat (3) @(negedge clk);
    bus_read(2'd0, rd); chk(rd == 0, "R1 pend in reset", rd, 0);
    chk(irq_req == 1'b0, "R1 irq in reset", 32'(irq_req), 0);
    drive(16'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    bus_read(2'd0, rd); chk(rd == 0, "R1 pend", rd, 0);
    bus_read(2'd1, rd); chk(rd == 0, "R1 mask", rd, 0);
    chk(irq_req == 1'b0, "R1 irq", 32'(irq_req), 0);
    chk(irq_vector == 8'h40, "R1 vector", 32'(irq_vector), 32'h40);

    // R5: pending but fully masked
    drive(16'hFFFF); @(negedge clk); @(negedge clk);
    chk(irq_req == 1'b0, "R5 masked", 32'(irq_req), 0);
    chk(irq_vector == 8'h40, "R8 masked", 32'(irq_vector), 32'h40);

    // R4: mask write/readback, low half dropped
    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_read(2'd1, rd); chk(rd == 32'hFFFF_0000, "R4 mask readback", rd, 32'hFFFF_0000);
    chk(irq_vector == 8'h00, "R6 all pending", 32'(irq_vector), 0);
    bus_read(2'd2, rd); chk(rd == 32'h0000_0000, "R7 vec read idx0", rd, 0);

    // R3: writing pending address changes nothing
    drive(16'h0A50); @(negedge clk); @(negedge clk);
    bus_write(2'd0, 32'hFFFF_FFFF);
    bus_read(2'd0, rd); chk(rd == to_word(16'h0A50), "R3 pend write ignored", rd, to_word(16'h0A50));
    chk(irq_vector == exp_code(16'h0A50, 16'hFFFF), "R3 vector kept", 32'(irq_vector), 32'(exp_code(16'h0A50, 16'hFFFF)));

    // R4: only index 1 (level 0)
    bus_write(2'd1, 32'h4000_0000);
    drive(16'hFFFF); @(negedge clk); @(negedge clk);
    chk(irq_vector == 8'h04, "R4 idx1 only", 32'(irq_vector), 32'h04);
    bus_read(2'd2, rd); chk(rd == 32'h0400_0000, "R7 vec read", rd, 32'h0400_0000);
    drive(16'hFFFD); @(negedge clk); @(negedge clk);
    chk(irq_req == 1'b0, "R5 idx1 idle", 32'(irq_req), 0);

    // R9: reserved address, write-strobe read
    bus_read(2'd3, rd); chk(rd == 0, "R9 reserved", rd, 0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = '0; #1;
    chk(bus_rdata == 0, "R9 write cycle", bus_rdata, 0);
    bus_sel = 1'b0; bus_wr = 1'b0;

    // R6/R7/R8: exhaustive sweep under open mask, then partial masks
    bus_write(2'd1, 32'hFFFF_0000);
    sweep(16'hFFFF, 65536, 1, "open");
    bus_write(2'd1, 32'hAAAA_0000);
    sweep(16'h5555, 4096, 40503, "pins");
    bus_write(2'd1, 32'h5555_0000);
    sweep(16'hAAAA, 4096, 40503, "levels");
    bus_write(2'd1, 32'h0001_0000);
    sweep(16'h8000, 2048, 37, "idx15");
    bus_write(2'd1, 32'h8000_0000);
    sweep(16'h0001, 2048, 37, "idx0");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule